// File: doc/BRIEF.md
# Inter-Processor Event Flag Unit

This block carries numbered event flags from one processor, the sender, to a second processor, the receiver. Each processor reaches the block through its own synchronous register port. The sender raises events by writing ones to a set strobe. It sees the pending events through a flag view. It can withdraw events that are still pending through a cancel strobe. The receiver sees the same storage through a status view and retires events through an acknowledge strobe. Both clearing paths have the same effect, and a single write may touch any number of bits.

The four lowest flags also drive interrupt lines toward the receiver. Each line gives a one-cycle pulse when its flag goes from clear to set. The higher flags can only be polled. One instance serves one direction. Two mirrored instances give a bidirectional pair. The interrupt controller that takes the pulses sits outside the block.

Top module: `ipc_event_flags`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all flags, both read-data outputs and all interrupt lines become 0.
- R2: A sender write to address 0 (set strobe) sets every flag whose bit in `snd_wdata` is 1. Bits written as 0 leave their flags unchanged.
- R3: A read of sender address 2 (flag view) and a read of receiver address 1 (status view) return the same flag vector. Bit n of that vector is flag n.
- R4: A receiver write to address 0 (acknowledge strobe) clears every flag whose bit in `rcv_wdata` is 1. Other flags are unchanged.
- R5: A sender write to address 1 (cancel strobe) clears flags exactly as an acknowledge does. An acknowledge and a cancel in the same cycle both take effect.
- R6: When a set and a clear (acknowledge or cancel) hit the same bit in the same cycle, the flag ends up set.
- R7: `irq_o[n]` for n in 0..3 is high for exactly one cycle: the first cycle in which flag n reads as 1 after having been 0. Setting a flag that is already set gives no pulse. Flags 4..31 never drive an interrupt.
- R8: Reads of the strobe addresses (sender 0, 1 and 3, receiver 0) return 0. Writes to the view addresses (sender 2, receiver 1) change no flag.
- R9: Read data is registered. It shows the addressed value in the cycle after a read request, taken before any write in the same cycle, and is 0 in a cycle after no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_wr | input | 1 | Sender write request |
| snd_rd | input | 1 | Sender read request |
| snd_addr | input | 2 | Sender register address: 0 set, 1 cancel, 2 flag view |
| snd_wdata | input | 32 | Sender write data, one bit per flag |
| snd_rdata | output | 32 | Sender registered read data |
| rcv_wr | input | 1 | Receiver write request |
| rcv_rd | input | 1 | Receiver read request |
| rcv_addr | input | 1 | Receiver register address: 0 acknowledge, 1 status view |
| rcv_wdata | input | 32 | Receiver write data, one bit per flag |
| rcv_rdata | output | 32 | Receiver registered read data |
| irq_o | output | 4 | Per-flag interrupt pulses for flags 0..3 |

## Verification
The bench drives a set and an acknowledge at the same bit in the same cycle. A design that let the clear win would lose the event and show a 0 where a 1 is expected. It sets flags that are already set. A design that pulses on the write instead of on the transition would show a spurious interrupt. It also sets upper-bit flags, which a design that decodes too many interrupt lines would turn into pulses. Writes to the view addresses and reads of the strobe addresses catch a block that decodes addresses loosely. A same-cycle acknowledge plus cancel catches a block that drops one of the two clear sources.

// File: rtl/ipc_event_flags.sv
module ipc_event_flags #(
  parameter int NFLAGS = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_wr,
  input  logic              snd_rd,
  input  logic [1:0]        snd_addr,
  input  logic [NFLAGS-1:0] snd_wdata,
  output logic [NFLAGS-1:0] snd_rdata,
  input  logic              rcv_wr,
  input  logic              rcv_rd,
  input  logic              rcv_addr,
  input  logic [NFLAGS-1:0] rcv_wdata,
  output logic [NFLAGS-1:0] rcv_rdata,
  output logic [NIRQ-1:0]   irq_o
);
  localparam logic [1:0] S_SET    = 2'd0;
  localparam logic [1:0] S_CANCEL = 2'd1;
  localparam logic [1:0] S_VIEW   = 2'd2;
  localparam logic       R_ACK    = 1'b0;
  localparam logic       R_VIEW   = 1'b1;

  logic [NFLAGS-1:0] flags_q;
  logic [NFLAGS-1:0] set_v, clr_v;

  assign set_v = (snd_wr && snd_addr == S_SET) ? snd_wdata : '0;
  assign clr_v = ((snd_wr && snd_addr == S_CANCEL) ? snd_wdata : '0)
               | ((rcv_wr && rcv_addr == R_ACK)    ? rcv_wdata : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      irq_o     <= '0;
      snd_rdata <= '0;
      rcv_rdata <= '0;
    end else begin
      flags_q   <= (flags_q & ~clr_v) | set_v;
      irq_o     <= set_v[NIRQ-1:0] & ~flags_q[NIRQ-1:0];
      snd_rdata <= (snd_rd && snd_addr == S_VIEW) ? flags_q : '0;
      rcv_rdata <= (rcv_rd && rcv_addr == R_VIEW) ? flags_q : '0;
    end
  end
endmodule

module ipc_event_flags_chk #(
  parameter int NFLAGS = 32,
  parameter int NIRQ   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snd_wr,
  input logic              snd_rd,
  input logic [1:0]        snd_addr,
  input logic [NFLAGS-1:0] snd_wdata,
  input logic [NFLAGS-1:0] snd_rdata,
  input logic              rcv_wr,
  input logic              rcv_rd,
  input logic              rcv_addr,
  input logic [NFLAGS-1:0] rcv_wdata,
  input logic [NFLAGS-1:0] rcv_rdata,
  input logic [NIRQ-1:0]   irq_o,
  input logic [NFLAGS-1:0] flags_q
);
  // R7
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flags_q[NIRQ-1:0] & ~$past(flags_q[NIRQ-1:0])));
  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |=> ((irq_o & $past(irq_o)) == '0));
  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr && snd_addr == 2'd0) |=> ((flags_q & $past(snd_wdata)) == $past(snd_wdata)));
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_wr && rcv_addr == 1'b0 && !(snd_wr && snd_addr == 2'd0))
      |=> ((flags_q & $past(rcv_wdata)) == '0));
  // R5
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr && snd_addr == 2'd1) |=> ((flags_q & $past(snd_wdata)) == '0));
  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(snd_wr && snd_addr != 2'd2) && !(rcv_wr && rcv_addr == 1'b0)) |=> $stable(flags_q));
  // R3
  views_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_rd && snd_addr == 2'd2 && rcv_rd && rcv_addr == 1'b1) |=> (snd_rdata == rcv_rdata));
  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snd_rd && !rcv_rd) |=> (snd_rdata == '0 && rcv_rdata == '0));
endmodule

bind ipc_event_flags ipc_event_flags_chk #(.NFLAGS(NFLAGS), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/tb_ipc_event_flags.sv
module tb_ipc_event_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snd_wr = 1'b0, snd_rd = 1'b0, rcv_wr = 1'b0, rcv_rd = 1'b0, rcv_addr = 1'b0;
  logic [1:0]  snd_addr = 2'd0;
  logic [31:0] snd_wdata = '0, rcv_wdata = '0, snd_rdata, rcv_rdata;
  logic [3:0]  irq_o;

  always #4 clk = ~clk;

  ipc_event_flags dut (.*);

  typedef struct { int at; int sel; logic [31:0] val; int req; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  logic [31:0] m = '0;
  bit done = 0;

  task automatic op(input bit sw, input logic [1:0] sa, input logic [31:0] sd, input bit sr,
                    input bit rw, input bit ra, input logic [31:0] rd, input bit rr, input int req);
    logic [31:0] s, c;
    @(negedge clk);
    snd_wr = sw; snd_addr = sa; snd_wdata = sd; snd_rd = sr;
    rcv_wr = rw; rcv_addr = ra; rcv_wdata = rd; rcv_rd = rr;
    s = (sw && sa == 2'd0) ? sd : '0;
    c = ((sw && sa == 2'd1) ? sd : '0) | ((rw && ra == 1'b0) ? rd : '0);
    q.push_back('{cyc + 1, 0, (sr && sa == 2'd2) ? m : 32'h0, req});
    q.push_back('{cyc + 1, 1, (rr && ra == 1'b1) ? m : 32'h0, req});
    q.push_back('{cyc + 1, 2, {28'h0, s[3:0] & ~m[3:0]}, req});
    m = (m & ~c) | s;
  endtask

  task automatic look(input int req);
    op(0, 2'd2, '0, 1, 0, 1'b1, '0, 1, req);
  endtask

  always @(posedge clk) begin
    #2;
    cyc++;
    while (q.size() > 0 && q[0].at == cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? snd_rdata : (it.sel == 1) ? rcv_rdata : {28'h0, irq_o};
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL R%0d output %0d: actual %h expected %h", it.req, it.sel, act, it.val);
      end
    end
    if (cyc > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(1);                                        // R1 flags zero after reset
    op(1, 2'd0, 32'h0001_0008, 0, 0, 1'b0, '0, 0, 2); // R2, R7 pulse on bit 3
    look(3);                                        // R3 both views agree
    op(1, 2'd0, 32'h0000_0008, 1, 0, 1'b1, '0, 1, 7); // R7 re-set: no pulse
    op(1, 2'd0, 32'hF000_0000, 0, 0, 1'b0, '0, 0, 7); // R7 upper flags no irq
    look(2);
    op(0, 2'd0, '0, 0, 1, 1'b0, 32'h0001_0000, 0, 4); // R4 acknowledge
    look(4);
    op(1, 2'd1, 32'h0000_0008, 0, 0, 1'b0, '0, 0, 5); // R5 cancel
    look(5);
    op(1, 2'd0, 32'h0000_000F, 0, 1, 1'b0, 32'h0000_0003, 0, 6); // R6 set wins
    look(6);
    op(1, 2'd1, 32'h0000_0005, 0, 1, 1'b0, 32'h1000_0002, 0, 5); // R5 ack+cancel
    look(5);
    op(1, 2'd2, 32'hFFFF_FFFF, 0, 1, 1'b1, 32'hFFFF_FFFF, 0, 8); // R8 view writes ignored
    look(8);
    op(0, 2'd0, '0, 1, 0, 1'b0, '0, 1, 8);           // R8 strobe reads zero
    op(0, 2'd1, '0, 1, 0, 1'b0, '0, 0, 8);
    op(0, 2'd3, '0, 1, 0, 1'b0, '0, 0, 8);
    op(1, 2'd0, 32'h0000_0000, 0, 0, 1'b0, '0, 0, 2); // R2 zero write no effect
    op(0, 2'd2, '0, 0, 0, 1'b1, '0, 0, 9);           // R9 no read -> zero
    op(1, 2'd0, 32'hFFFF_FFFF, 1, 0, 1'b1, '0, 1, 9); // R9 read shows pre-write value
    look(7);
    op(0, 2'd0, '0, 0, 1, 1'b0, 32'hFFFF_FFFF, 0, 4);
    look(4);
    op(0, 2'd0, '0, 0, 0, 1'b0, '0, 0, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule